// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small 32-bit processor core that finishes each instruction within one clock period. Every instruction goes through the same steps. The core fetches the word addressed by the program counter and reads up to two registers. It then sends operands through a single ALU, which computes a load or store address, an arithmetic or logic result, or an equality test for a branch. Last, the core commits the result to the register file or the data memory, or redirects the program counter.

The instruction and data memories are small word arrays inside the core. While reset is held, a preload port fills either array one word per clock. Once reset is released the core executes from address 0. The register write port and the data-memory write port are brought out as output strobes, so a testbench or a neighbouring block can observe each architectural update as it happens.

The control half decodes the opcode and function fields into a packed set of strobes. The datapath half holds all the state and the arithmetic.

Top module: `onecyc_core`

## Requirements
- R1: Reset is synchronous and active high. A rising edge with `rst` high sets the program counter to 0 and clears all 32 registers. While `rst` is high, `regWrEn` and `memWrEn` stay low.
- R2: Without a taken branch, the program counter is 4 larger after each rising edge. `pcOut` shows the address of the instruction now executing.
- R3: Branch-if-equal uses opcode 6'h04 and is taken when registers rs and rt hold equal values, tested as a zero result of an ALU subtraction. The next address is then PC+4 plus the sign-extended 16-bit offset shifted left by two.
- R4: Register 0 always reads as zero. An instruction whose destination is register 0 raises no `regWrEn` and changes no state.
- R5: The ALU codes are 3'b000 AND, 3'b001 OR, 3'b010 ADD and 3'b110 SUB. The top code bit inverts operand B and supplies the carry-in. R-type function codes 6'h20 (add), 6'h22 (sub), 6'h24 (and) and 6'h25 (or) select these operations.
- R6: ALU code 3'b111, selected by R-type function code 6'h2A, yields 1 when rs is less than rt as signed 32-bit numbers, with overflow taken into account, and 0 otherwise. Bits 31 to 1 of the result are zero.
- R7: Load word (opcode 6'h23) reads the data word at rs plus the sign-extended offset [15:0] and writes it to register rt in the same cycle.
- R8: Store word (opcode 6'h2B) writes the value of register rt to data memory at rs plus the sign-extended offset. It raises `memWrEn` with that address and data and writes no register.
- R9: Instructions use these fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0]. R-type instructions (opcode 6'h00) write register rd.
- R10: An unrecognised opcode, or an R-type instruction with an unrecognised function code, writes no register and no memory, and the program counter advances by 4.
- R11: The preload port writes the selected memory only on a rising edge while `rst` is high. When `rst` is low, `loadEn` has no effect.
- R12: Both memories are indexed by address bits [log2(MEM_WORDS)+1:2], which are [7:2] at the default depth of 64 words. All other address bits are ignored, so addresses wrap modulo the memory size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| loadEn | input | 1 | Preload write strobe, honoured only while `rst` is high |
| loadToData | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| loadAddr | input | log2(MEM_WORDS) | Preload word index |
| loadData | input | 32 | Preload word |
| pcOut | output | 32 | Address of the instruction executing this cycle |
| regWrEn | output | 1 | A register is written at the next rising edge |
| regWrAddr | output | 5 | Destination register number |
| regWrData | output | 32 | Value written to the destination register |
| memWrEn | output | 1 | Data memory is written at the next rising edge |
| memWrAddr | output | 32 | Byte address of the store |
| memWrData | output | 32 | Word stored |

## Verification
The register-write and store strobes, with their addresses and data, depend only on state. They are valid in the same cycle as the instruction that `pcOut` shows, before the rising edge that commits them. The program counter that follows shows on `pcOut` one edge later. The bench therefore drives and samples 1 ns after each falling edge. It compares the strobes of the current instruction against a bench-side instruction model, commits the model, and checks the model's next address against `pcOut` in the following cycle. Preload words are written during reset, and random preload traffic during execution must leave the lockstep comparison unchanged.

// File: rtl/onecyc_pkg.sv
package onecyc_pkg;

  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  // Opcode field [31:26]
  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;

  // Function field [5:0] of R-type words
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  // ALU steering: bit 2 negates operand B, bits 1:0 pick the result
  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } aluCode_e;

  // Class of ALU use chosen by the main decoder
  typedef enum logic [1:0] {
    ALUOP_ADD   = 2'b00,
    ALUOP_SUB   = 2'b01,
    ALUOP_FUNCT = 2'b10,
    ALUOP_NONE  = 2'b11
  } aluOp_e;

  typedef struct packed {
    logic     regWrite;
    logic     destIsRd;
    logic     srcImm;
    logic     memWrite;
    logic     memToReg;
    logic     branch;
    aluCode_e aluCode;
  } ctrlStrobes_t;

endpackage

// File: rtl/onecyc_alu.sv
module onecyc_alu
  import onecyc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluCode_e     code,
  output logic [W-1:0] result,
  output logic         isZero
);

  logic         negB;
  logic [W-1:0] bEff;
  logic [W-1:0] sum;
  logic         ovf;
  logic         less;

  // Subtraction is A + ~B + 1: the negate bit doubles as carry-in
  assign negB = code[2];
  assign bEff = negB ? ~opB : opB;
  assign sum  = opA + bEff + {{(W-1){1'b0}}, negB};

  // Signed compare must survive overflow of A - B
  assign ovf  = (opA[W-1] == bEff[W-1]) && (sum[W-1] != opA[W-1]);
  assign less = sum[W-1] ^ ovf;

  always_comb begin
    case (code[1:0])
      2'b00:   result = opA & bEff;
      2'b01:   result = opA | bEff;
      2'b10:   result = sum;
      default: result = {{(W-1){1'b0}}, less};
    endcase
  end

  assign isZero = (result == '0);

endmodule

// File: rtl/onecyc_regfile.sv
module onecyc_regfile #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rdAddrA,
  input  logic [AW-1:0] rdAddrB,
  output logic [W-1:0]  rdDataA,
  output logic [W-1:0]  rdDataB,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  // Register 0 is a hard zero on both read ports
  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];

  AST_REG_WRITE: assert property (@(posedge clk) disable iff (rst) (wrEn && (wrAddr != '0)) |=> (regs[$past(wrAddr)] == $past(wrData)));  // R4
  AST_REG_RESET: assert property (@(posedge clk) $past(rst) |-> ((rdAddrA == '0) || (rdDataA == '0) || !rst || 1'b0) || (rdDataA == '0));  // R1

endmodule

// File: rtl/onecyc_ctrl.sv
module onecyc_ctrl
  import onecyc_pkg::*;
(
  input  logic [5:0]   opcode,
  input  logic [5:0]   funct,
  output ctrlStrobes_t strobes
);

  ctrlStrobes_t base;
  aluOp_e       aluOp;
  aluCode_e     fnCode;
  logic         fnKnown;

  // Main decoder: instruction class -> strobes
  always_comb begin
    base     = '0;
    aluOp    = ALUOP_NONE;
    case (opcode)
      OPC_RTYPE: begin
        base.regWrite = 1'b1;
        base.destIsRd = 1'b1;
        aluOp         = ALUOP_FUNCT;
      end
      OPC_LW: begin
        base.regWrite = 1'b1;
        base.srcImm   = 1'b1;
        base.memToReg = 1'b1;
        aluOp         = ALUOP_ADD;
      end
      OPC_SW: begin
        base.memWrite = 1'b1;
        base.srcImm   = 1'b1;
        aluOp         = ALUOP_ADD;
      end
      OPC_BEQ: begin
        base.branch   = 1'b1;
        aluOp         = ALUOP_SUB;
      end
      default: aluOp = ALUOP_NONE;
    endcase
  end

  // Function-field decoder for R-type words
  always_comb begin
    fnKnown = 1'b1;
    case (funct)
      FN_ADD:  fnCode = ALU_ADD;
      FN_SUB:  fnCode = ALU_SUB;
      FN_AND:  fnCode = ALU_AND;
      FN_OR:   fnCode = ALU_OR;
      FN_SLT:  fnCode = ALU_SLT;
      default: begin
        fnCode  = ALU_AND;
        fnKnown = 1'b0;
      end
    endcase
  end

  // ALU control and final strobe merge
  always_comb begin
    strobes = base;
    case (aluOp)
      ALUOP_ADD:   strobes.aluCode = ALU_ADD;
      ALUOP_SUB:   strobes.aluCode = ALU_SUB;
      ALUOP_FUNCT: begin
        strobes.aluCode  = fnCode;
        strobes.regWrite = base.regWrite && fnKnown;
      end
      default:     strobes.aluCode = ALU_AND;
    endcase
  end

endmodule

// File: rtl/onecyc_datapath.sv
module onecyc_datapath
  import onecyc_pkg::*;
#(
  parameter  int MEM_WORDS = 64,
  localparam int MEM_AW    = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic              loadToData,
  input  logic [MEM_AW-1:0] loadAddr,
  input  logic [XLEN-1:0]   loadData,
  input  ctrlStrobes_t      strobes,
  output logic [5:0]        opcode,
  output logic [5:0]        funct,
  output logic [XLEN-1:0]   pcOut,
  output logic              regWrEn,
  output logic [REG_AW-1:0] regWrAddr,
  output logic [XLEN-1:0]   regWrData,
  output logic              memWrEn,
  output logic [XLEN-1:0]   memWrAddr,
  output logic [XLEN-1:0]   memWrData
);

  logic [XLEN-1:0]   imem [MEM_WORDS];
  logic [XLEN-1:0]   dmem [MEM_WORDS];

  logic [XLEN-1:0]   pc;
  logic [XLEN-1:0]   pcPlus4;
  logic [XLEN-1:0]   branchTarget;
  logic [XLEN-1:0]   pcNext;
  logic [XLEN-1:0]   instr;
  logic [XLEN-1:0]   immExt;
  logic [XLEN-1:0]   srcA;
  logic [XLEN-1:0]   rtVal;
  logic [XLEN-1:0]   aluB;
  logic [XLEN-1:0]   aluY;
  logic [XLEN-1:0]   memRdata;
  logic [XLEN-1:0]   wbData;
  logic [REG_AW-1:0] rsIdx;
  logic [REG_AW-1:0] rtIdx;
  logic [REG_AW-1:0] rdIdx;
  logic [REG_AW-1:0] destIdx;
  logic [MEM_AW-1:0] dIdx;
  logic              aluZero;
  logic              takeBranch;
  logic              regWe;
  logic              memWe;

  // Fetch and field split
  assign instr  = imem[pc[MEM_AW+1:2]];
  assign opcode = instr[31:26];
  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign rdIdx  = instr[15:11];
  assign funct  = instr[5:0];
  assign immExt = {{(XLEN-16){instr[15]}}, instr[15:0]};

  // Next-address logic
  assign pcPlus4      = pc + 32'd4;
  assign branchTarget = pcPlus4 + {immExt[XLEN-3:0], 2'b00};
  assign takeBranch   = strobes.branch && aluZero;
  assign pcNext       = takeBranch ? branchTarget : pcPlus4;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  // Register file and operand selection
  assign destIdx = strobes.destIsRd ? rdIdx : rtIdx;
  assign regWe   = strobes.regWrite && !rst && (destIdx != '0);

  onecyc_regfile #(
    .W  (XLEN),
    .AW (REG_AW)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .rdAddrA (rsIdx),
    .rdAddrB (rtIdx),
    .rdDataA (srcA),
    .rdDataB (rtVal),
    .wrEn    (regWe),
    .wrAddr  (destIdx),
    .wrData  (wbData)
  );

  assign aluB = strobes.srcImm ? immExt : rtVal;

  onecyc_alu #(
    .W (XLEN)
  ) u_alu (
    .opA    (srcA),
    .opB    (aluB),
    .code   (strobes.aluCode),
    .result (aluY),
    .isZero (aluZero)
  );

  // Data memory and write-back
  assign dIdx     = aluY[MEM_AW+1:2];
  assign memRdata = dmem[dIdx];
  assign wbData   = strobes.memToReg ? memRdata : aluY;
  assign memWe    = strobes.memWrite && !rst;

  always_ff @(posedge clk) begin
    if (rst && loadEn && loadToData) dmem[loadAddr] <= loadData;
    else if (memWe)                  dmem[dIdx]     <= rtVal;
  end

  always_ff @(posedge clk) begin
    if (rst && loadEn && !loadToData) imem[loadAddr] <= loadData;
  end

  assign pcOut     = pc;
  assign regWrEn   = regWe;
  assign regWrAddr = destIdx;
  assign regWrData = wbData;
  assign memWrEn   = memWe;
  assign memWrAddr = aluY;
  assign memWrData = rtVal;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst) !takeBranch |=> (pc == $past(pc) + 32'd4));  // R2
  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst) takeBranch |=> (pc == $past(pc) + 32'd4 + {$past(immExt[XLEN-3:0]), 2'b00}));  // R3
  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst) (rsIdx == '0) |-> (srcA == '0));  // R4
  AST_SLT_BIT: assert property (@(posedge clk) disable iff (rst) (strobes.aluCode == ALU_SLT) |-> (aluY[XLEN-1:1] == '0));  // R6
  AST_STORE_DATA: assert property (@(posedge clk) disable iff (rst) memWe |=> (dmem[$past(dIdx)] == $past(rtVal)));  // R8
  AST_RESET_PC: assert property (@(posedge clk) $past(rst) |-> (pc == '0));  // R1

endmodule

// File: rtl/onecyc_core.sv
module onecyc_core
  import onecyc_pkg::*;
#(
  parameter  int MEM_WORDS = 64,
  localparam int MEM_AW    = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic              loadToData,
  input  logic [MEM_AW-1:0] loadAddr,
  input  logic [31:0]       loadData,
  output logic [31:0]       pcOut,
  output logic              regWrEn,
  output logic [4:0]        regWrAddr,
  output logic [31:0]       regWrData,
  output logic              memWrEn,
  output logic [31:0]       memWrAddr,
  output logic [31:0]       memWrData
);

  ctrlStrobes_t strobes;
  logic [5:0]   opcode;
  logic [5:0]   funct;

  onecyc_ctrl u_ctrl (
    .opcode  (opcode),
    .funct   (funct),
    .strobes (strobes)
  );

  onecyc_datapath #(
    .MEM_WORDS (MEM_WORDS)
  ) u_path (
    .clk        (clk),
    .rst        (rst),
    .loadEn     (loadEn),
    .loadToData (loadToData),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .strobes    (strobes),
    .opcode     (opcode),
    .funct      (funct),
    .pcOut      (pcOut),
    .regWrEn    (regWrEn),
    .regWrAddr  (regWrAddr),
    .regWrData  (regWrData),
    .memWrEn    (memWrEn),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData)
  );

endmodule

// File: tb/onecyc_core_tb.sv
`timescale 1ns/1ps
module onecyc_core_tb;

  localparam int MW = 64;

  logic        clk;
  logic        rst;
  logic        loadEn;
  logic        loadToData;
  logic [5:0]  loadAddr;
  logic [31:0] loadData;
  logic [31:0] pcOut;
  logic        regWrEn;
  logic [4:0]  regWrAddr;
  logic [31:0] regWrData;
  logic        memWrEn;
  logic [31:0] memWrAddr;
  logic [31:0] memWrData;

  onecyc_core #(.MEM_WORDS(MW)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .loadEn     (loadEn),
    .loadToData (loadToData),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .pcOut      (pcOut),
    .regWrEn    (regWrEn),
    .regWrAddr  (regWrAddr),
    .regWrData  (regWrData),
    .memWrEn    (memWrEn),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int unsigned nChecks = 0;
  int unsigned nErrors = 0;
  bit          finished = 1'b0;

  // Bench-side instruction model
  logic [31:0] mImem [MW];
  logic [31:0] mDmem [MW];
  logic [31:0] mRegs [32];
  logic [31:0] mPc;
  string       pcTag;

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rType(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'h00, fn};
  endfunction

  function automatic logic [31:0] iType(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  // Evaluate the instruction at mPc, compare with the ports, then commit
  task automatic stepAndCheck();
    logic [31:0] ins, a, b, immX, res, nextPc;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd;
    bit          eWe, eMwe, ok;
    logic [4:0]  eWa;
    logic [31:0] eWd, eMa, eMd;
    string       eTag;
    ins  = mImem[mPc[7:2]];
    op   = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; fn = ins[5:0];
    immX = {{16{ins[15]}}, ins[15:0]};
    a    = mRegs[rs]; b = mRegs[rt];
    eWe = 0; eWa = '0; eWd = '0; eMwe = 0; eMa = '0; eMd = '0; res = '0; ok = 1;
    nextPc = mPc + 32'd4;
    eTag = "R10";
    case (op)
      6'h00: begin
        case (fn)
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          6'h2A: res = {31'b0, ($signed(a) < $signed(b))};
          default: ok = 0;
        endcase
        if (ok) begin
          eTag = (fn == 6'h2A) ? "R6 R9" : "R5 R9";
          if (rd != 0) begin eWe = 1; eWa = rd; eWd = res; end
          else eTag = "R4";
        end
      end
      6'h23: begin
        eTag = "R7 R11 R12";
        if (rt != 0) begin eWe = 1; eWa = rt; eWd = mDmem[(a + immX) >> 2 & 32'h3F]; end
        else eTag = "R4";
      end
      6'h2B: begin
        eTag = "R8 R12";
        eMwe = 1; eMa = a + immX; eMd = b;
      end
      6'h04: begin
        eTag = "R3";
        if (a == b) nextPc = mPc + 32'd4 + {immX[29:0], 2'b00};
      end
      default: eTag = "R10";
    endcase
    check32(pcTag, "pcOut", pcOut, mPc);
    check32(eTag, "regWrEn", {31'b0, regWrEn}, {31'b0, eWe});
    if (eWe) begin
      check32(eTag, "regWrAddr", {27'b0, regWrAddr}, {27'b0, eWa});
      check32(eTag, "regWrData", regWrData, eWd);
    end
    check32(eTag, "memWrEn", {31'b0, memWrEn}, {31'b0, eMwe});
    if (eMwe) begin
      check32(eTag, "memWrAddr", memWrAddr, eMa);
      check32(eTag, "memWrData", memWrData, eMd);
    end
    if (eWe)  mRegs[eWa] = eWd;
    if (eMwe) mDmem[eMa[7:2]] = eMd;
    pcTag = (op == 6'h04) ? "R3" : "R2";
    mPc   = nextPc;
  endtask

  // Reset, preload both memories, then run in lockstep with the model
  task automatic runSession(int cycles, bit noisyLoad);
    rst = 1'b1; loadEn = 1'b0; loadToData = 1'b0; loadAddr = '0; loadData = '0;
    @(negedge clk);
    #1;
    check32("R1", "pcOut in reset", pcOut, 32'h0);
    for (int i = 0; i < MW; i++) begin
      loadEn = 1'b1; loadToData = 1'b0; loadAddr = 6'(i); loadData = mImem[i];
      @(negedge clk);
    end
    for (int i = 0; i < MW; i++) begin
      loadEn = 1'b1; loadToData = 1'b1; loadAddr = 6'(i); loadData = mDmem[i];
      @(negedge clk);
    end
    loadEn = 1'b0;
    #1;
    check32("R1", "regWrEn in reset", {31'b0, regWrEn}, 32'h0);
    check32("R1", "memWrEn in reset", {31'b0, memWrEn}, 32'h0);
    for (int i = 0; i < 32; i++) mRegs[i] = '0;
    mPc   = '0;
    pcTag = "R1";
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      #1;
      stepAndCheck();
      @(negedge clk);
      if (noisyLoad) begin
        // R11: preload traffic while running must be ignored
        loadEn = 1'b1; loadToData = $urandom_range(0, 1) == 1;
        loadAddr = 6'($urandom_range(0, MW - 1)); loadData = $urandom;
      end
    end
    loadEn = 1'b0;
  endtask

  function automatic logic [31:0] randInstr();
    logic [4:0]  rs, rt, rd;
    logic [5:0]  fn;
    int          k;
    rs = 5'($urandom_range(0, 7));
    rt = 5'($urandom_range(0, 7));
    rd = 5'($urandom_range(0, 7));
    k  = $urandom_range(0, 9);
    if (k <= 4) begin
      case ($urandom_range(0, 5))
        0: fn = 6'h20; 1: fn = 6'h22; 2: fn = 6'h24; 3: fn = 6'h25; 4: fn = 6'h2A;
        default: fn = 6'h03;
      endcase
      return rType(rs, rt, rd, fn);
    end
    if (k <= 6) return iType(6'h23, rs, rt, 16'($urandom));
    if (k == 7) return iType(6'h2B, rs, rt, 16'($urandom));
    if (k == 8) return iType(6'h04, rs, rt, 16'($signed($urandom_range(0, 8)) - 4));
    case ($urandom_range(0, 3))
      0: return iType(6'h01, rs, rt, 16'h1234);
      1: return iType(6'h08, rs, rt, 16'h0004);
      2: return iType(6'h3F, rs, rt, 16'hFFFF);
      default: return iType(6'h2F, rs, rt, 16'h0000);
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5EED_0001));
    rst = 1'b1; loadEn = 1'b0; loadToData = 1'b0; loadAddr = '0; loadData = '0;
    pcTag = "R1";

    // Directed program: signed compares, overflow, r0, store/load, branches, aliasing
    for (int i = 0; i < MW; i++) begin
      mImem[i] = 32'h0;
      mDmem[i] = 32'h0101_0101 * i;
    end
    mDmem[0] = 32'h7FFF_FFFF; mDmem[1] = 32'h8000_0000;
    mDmem[2] = 32'd5;         mDmem[3] = 32'hFFFF_FFFB;
    mImem[0]  = iType(6'h23, 5'd0, 5'd1, 16'd0);
    mImem[1]  = iType(6'h23, 5'd0, 5'd2, 16'd4);
    mImem[2]  = iType(6'h23, 5'd0, 5'd3, 16'd8);
    mImem[3]  = iType(6'h23, 5'd0, 5'd4, 16'd12);
    mImem[4]  = rType(5'd1, 5'd2, 5'd5, 6'h2A);   // R6 overflow case -> 0
    mImem[5]  = rType(5'd2, 5'd1, 5'd6, 6'h2A);   // R6 -> 1
    mImem[6]  = rType(5'd4, 5'd3, 5'd7, 6'h2A);   // R6 -5 < 5 -> 1
    mImem[7]  = rType(5'd1, 5'd3, 5'd8, 6'h20);   // R5 add wraps
    mImem[8]  = rType(5'd3, 5'd4, 5'd9, 6'h22);   // R5 sub -> 10
    mImem[9]  = rType(5'd1, 5'd4, 5'd10, 6'h24);
    mImem[10] = rType(5'd2, 5'd3, 5'd11, 6'h25);
    mImem[11] = rType(5'd1, 5'd1, 5'd0, 6'h20);   // R4 write to r0 ignored
    mImem[12] = iType(6'h2B, 5'd0, 5'd9, 16'd16); // R8
    mImem[13] = iType(6'h23, 5'd3, 5'd12, 16'hFFFC); // R7 negative offset, low bits ignored
    mImem[14] = iType(6'h23, 5'd0, 5'd13, 16'd16);
    mImem[15] = iType(6'h04, 5'd3, 5'd4, 16'd5);  // R3 not taken
    mImem[16] = iType(6'h04, 5'd9, 5'd13, 16'd2); // R3 taken to word 19
    mImem[17] = rType(5'd1, 5'd1, 5'd14, 6'h20);
    mImem[18] = rType(5'd1, 5'd1, 5'd14, 6'h20);
    mImem[19] = iType(6'h3F, 5'd1, 5'd2, 16'h0); // R10 unknown opcode
    mImem[20] = rType(5'd1, 5'd2, 5'd15, 6'h00); // R10 unknown function
    mImem[21] = iType(6'h23, 5'd0, 5'd15, 16'd256); // R12 wraps to word 0
    mImem[22] = iType(6'h04, 5'd0, 5'd0, 16'hFFFF); // R3 branch to itself
    runSession(40, 1'b1);

    // Constrained-random programs
    for (int s = 0; s < 12; s++) begin
      for (int i = 0; i < MW; i++) begin
        mDmem[i] = $urandom;
        mImem[i] = randInstr();
      end
      for (int i = 0; i < 6; i++) mImem[i] = iType(6'h23, 5'd0, 5'(i + 1), 16'(i * 4));
      if (s == 0) mDmem[1] = mDmem[2];
      runSession(300, s[0]);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

endmodule